// File: doc/BRIEF.md
# Multi-Cycle 32-bit Processor Core

This block is a small 32-bit processor that runs a five-instruction subset: register add and subtract, load word, store word, branch-if-equal and jump. An instruction is not finished in one long cycle. It is split into short steps of one clock each, and a state machine picks the next step from the opcode. Fetch and data traffic share one memory port. One ALU does all the arithmetic: the PC increment, the branch target, address generation and the register operations. The ALU is used again in later steps of the same instruction.

Between steps, each intermediate value sits in a holding register. These are the instruction register, the two operand latches, the ALU result latch and the memory data latch. As a result, a load takes five clocks, a store or register operation four, and a branch or jump three. The core connects to an external single-port memory. The memory's read data must be valid in the same cycle as the address. A combinational debug port lets a bench or a debugger read any architectural register.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the PC is 0 and the core is in its fetch step. Right after release, mem_addr is 0, instr_start is 1 and mem_we is 0.
- R2: In the fetch step, mem_addr equals the PC and the word read is latched as the instruction. The PC becomes PC+4 at the end of that step. With no taken branch or jump, successive fetch addresses rise by 4.
- R3: The ALU produces both the incremented PC and the branch target. At most one memory access is made per cycle. mem_we is high only in the single write step of a store.
- R4: Opcode 0x00 with funct 0x20 writes rs+rt into rd. With funct 0x22 it writes rs−rt into rd. The result wraps modulo 2^32.
- R5: Register 0 always reads as zero, even after an instruction names it as destination.
- R6: Load word (opcode 0x23) reads the word at rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. Negative offsets are allowed.
- R7: Store word (opcode 0x2B) writes rt to the address rs plus the sign-extended immediate, for exactly one cycle.
- R8: Branch-if-equal (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next fetch is at PC+4 plus the sign-extended immediate shifted left by 2, so immediate 0x0003 adds 0x0000000c. Otherwise the next fetch is at PC+4.
- R9: Jump (opcode 0x02) fetches next from the address {upper 4 bits of PC+4, bits 25:0, 2'b00}.
- R10: Cycles from one fetch to the next: 5 for a load, 4 for a store or register operation, and 3 for a branch or jump.
- R11: dbg_data shows the current value of the register selected by dbg_addr, in the same cycle.
- R12: Two encodings change no register or memory and take 2 cycles. The first is opcode 0x00 with a funct other than 0x20/0x22, or with bits 10:6 nonzero. The second is any opcode outside the five listed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address to unified memory |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as mem_addr |
| mem_we | output | 1 | Memory write enable |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Debug register value |
| instr_start | output | 1 | High during the fetch step of each instruction |

## Verification
The bench builds the core with its defaults: a 32-bit datapath, reset PC 0, and the ALU variant that makes subtraction by inverting the operand into the shared adder. That variant is the one that forms the branch comparison, so equal and unequal operands both reach the same carry-in path. Load data, the register operations and their operand choice are drawn from a seeded random source. Directed code adds a write to register 0, negative load/store offsets, a store followed by a reload, taken and untaken branches with immediate 3, a forward jump and an unsupported funct. An instruction-level model predicts every fetch address, every instruction length and the final register and memory contents.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_MEM_ADDR, S_MEM_READ, S_MEM_WB,
      S_MEM_WRITE, S_R_EXEC, S_R_WB, S_BRANCH, S_JUMP
   } state_e;

   typedef enum logic {ALU_ADD, ALU_SUB} alu_op_e;
   typedef enum logic [1:0] {BSEL_REG, BSEL_FOUR, BSEL_SEXT, BSEL_BOFF} bsel_e;
   typedef enum logic [1:0] {PCS_ALU, PCS_HELD, PCS_JUMP} pcsel_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_J     = 6'h02;
   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_SUB   = 6'h22;

   localparam int NREG = 32;
   localparam int RA_W = $clog2(NREG);

   typedef struct packed {
      logic    ir_we;
      logic    ab_we;
      logic    hold_we;
      logic    mdr_we;
      logic    pc_we;
      logic    take_if_zero;
      pcsel_e  pc_sel;
      logic    addr_from_hold;
      logic    mem_we;
      logic    a_from_reg;
      bsel_e   b_sel;
      alu_op_e alu_op;
      logic    rf_we;
      logic    dst_is_rd;
      logic    wb_from_mdr;
   } ctrl_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   generate
      if (SHARED_ADDER) begin : g_shared
         logic [W-1:0] b_eff;
         assign b_eff = (op == ALU_SUB) ? ~b : b;
         assign y = a + b_eff + {{(W-1){1'b0}}, (op == ALU_SUB)};
      end else begin : g_split
         assign y = (op == ALU_SUB) ? (a - b) : (a + b);
      end
   endgenerate
   assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W = 32,
   parameter int N = 32,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   output logic [W-1:0]  rd3,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [W-1:0] cells [N];

   generate
      if (N != (1 << AW)) begin : g_bad_n
         $error("mc_regfile: N must be a power of two");
      end
      for (genvar g = 0; g < N; g++) begin : g_cell
         if (g == 0) begin : g_zero
            assign cells[g] = '0;
         end else begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n) q <= '0;
               else if (we && wa == AW'(g)) q <= wd;
            end
            assign cells[g] = q;
         end
      end
   endgenerate

   assign rd1 = cells[ra1];
   assign rd2 = cells[ra2];
   assign rd3 = cells[ra3];

   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> (cells[$past(wa)] == $past(wd)));
   p_zero_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa == '0) |=> (rd3 == '0 || ra3 != '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic [4:0] shamt,
   output state_e     state,
   output ctrl_t      ctl
);
   state_e nxt;
   logic   r_ok;

   assign r_ok = (shamt == 5'd0) && (funct == FN_ADD || funct == FN_SUB);

   always_ff @(posedge clk) begin
      if (!rst_n) state <= S_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      ctl = '0;
      nxt = S_FETCH;
      unique case (state)
         S_FETCH: begin
            ctl.ir_we = 1'b1; ctl.pc_we = 1'b1; ctl.pc_sel = PCS_ALU;
            ctl.b_sel = BSEL_FOUR; ctl.alu_op = ALU_ADD;
            nxt = S_DECODE;
         end
         S_DECODE: begin
            ctl.ab_we = 1'b1; ctl.hold_we = 1'b1;
            ctl.b_sel = BSEL_BOFF; ctl.alu_op = ALU_ADD;
            case (opcode)
               OP_LW, OP_SW: nxt = S_MEM_ADDR;
               OP_RTYPE:     nxt = r_ok ? S_R_EXEC : S_FETCH;
               OP_BEQ:       nxt = S_BRANCH;
               OP_J:         nxt = S_JUMP;
               default:      nxt = S_FETCH;
            endcase
         end
         S_MEM_ADDR: begin
            ctl.a_from_reg = 1'b1; ctl.b_sel = BSEL_SEXT; ctl.hold_we = 1'b1;
            nxt = (opcode == OP_LW) ? S_MEM_READ : S_MEM_WRITE;
         end
         S_MEM_READ: begin
            ctl.addr_from_hold = 1'b1; ctl.mdr_we = 1'b1;
            nxt = S_MEM_WB;
         end
         S_MEM_WB: begin
            ctl.rf_we = 1'b1; ctl.wb_from_mdr = 1'b1;
         end
         S_MEM_WRITE: begin
            ctl.addr_from_hold = 1'b1; ctl.mem_we = 1'b1;
         end
         S_R_EXEC: begin
            ctl.a_from_reg = 1'b1; ctl.b_sel = BSEL_REG; ctl.hold_we = 1'b1;
            ctl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
            nxt = S_R_WB;
         end
         S_R_WB: begin
            ctl.rf_we = 1'b1; ctl.dst_is_rd = 1'b1;
         end
         S_BRANCH: begin
            ctl.a_from_reg = 1'b1; ctl.b_sel = BSEL_REG; ctl.alu_op = ALU_SUB;
            ctl.take_if_zero = 1'b1; ctl.pc_sel = PCS_HELD;
         end
         S_JUMP: begin
            ctl.pc_we = 1'b1; ctl.pc_sel = PCS_JUMP;
         end
         default: nxt = S_FETCH;
      endcase
   end

   p_decode_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH) |=> (state == S_DECODE));
   p_final_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MEM_WB || state == S_MEM_WRITE || state == S_R_WB ||
       state == S_BRANCH || state == S_JUMP) |=> (state == S_FETCH));
   p_load_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MEM_READ) |=> (state == S_MEM_WB));
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
   parameter int          DW           = 32,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [31:0]   mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          mem_we,
   input  logic [RA_W-1:0] dbg_addr,
   output logic [31:0]   dbg_data,
   output logic          instr_start
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("mc_core: instruction fields require DW == 32");
      end
   endgenerate

   state_e state;
   ctrl_t  ctl;

   logic [DW-1:0] pc, ir, a_q, b_q, hold_q, mdr_q;
   logic [DW-1:0] rs_val, rt_val, sext, alu_a, alu_b, alu_y, pc_nxt, wb_data;
   logic          alu_zero, pc_en;
   logic [RA_W-1:0] wb_addr;

   mc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .opcode(ir[31:26]), .funct(ir[5:0]), .shamt(ir[10:6]),
      .state(state), .ctl(ctl)
   );

   mc_regfile #(.W(DW), .N(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(ir[25:21]), .ra2(ir[20:16]), .ra3(dbg_addr),
      .rd1(rs_val), .rd2(rt_val), .rd3(dbg_data),
      .we(ctl.rf_we), .wa(wb_addr), .wd(wb_data)
   );

   assign sext  = {{(DW-16){ir[15]}}, ir[15:0]};
   assign alu_a = ctl.a_from_reg ? a_q : pc;
   always_comb begin
      unique case (ctl.b_sel)
         BSEL_REG:  alu_b = b_q;
         BSEL_FOUR: alu_b = DW'(4);
         BSEL_SEXT: alu_b = sext;
         default:   alu_b = {sext[DW-3:0], 2'b00};
      endcase
   end

   mc_alu #(.W(DW), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .a(alu_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
   );

   always_comb begin
      unique case (ctl.pc_sel)
         PCS_ALU:  pc_nxt = alu_y;
         PCS_HELD: pc_nxt = hold_q;
         default:  pc_nxt = {pc[DW-1:DW-4], ir[25:0], 2'b00};
      endcase
   end
   assign pc_en = ctl.pc_we | (ctl.take_if_zero & alu_zero);

   assign wb_addr = ctl.dst_is_rd ? ir[15:11] : ir[20:16];
   assign wb_data = ctl.wb_from_mdr ? mdr_q : hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= RESET_PC; ir <= '0; a_q <= '0; b_q <= '0;
         hold_q <= '0; mdr_q <= '0;
      end else begin
         if (pc_en)       pc     <= pc_nxt;
         if (ctl.ir_we)   ir     <= mem_rdata;
         if (ctl.ab_we)   begin a_q <= rs_val; b_q <= rt_val; end
         if (ctl.hold_we) hold_q <= alu_y;
         if (ctl.mdr_we)  mdr_q  <= mem_rdata;
      end
   end

   assign mem_addr    = ctl.addr_from_hold ? hold_q : pc;
   assign mem_wdata   = b_q;
   assign mem_we      = ctl.mem_we;
   assign instr_start = (state == S_FETCH);

   p_fetch_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH) |=> (pc == $past(pc) + DW'(4)));
   p_store_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   p_write_after_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(state) == S_MEM_ADDR));
   p_branch_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BRANCH && alu_zero) |=> (pc == $past(hold_q)));
   p_branch_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BRANCH && !alu_zero) |=> $stable(pc));
endmodule

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
   logic        mem_we, instr_start;
   logic [4:0]  dbg_addr = '0;

   always #4 clk = ~clk;

   logic [31:0] mem     [256];
   logic [31:0] ref_mem [256];
   logic [31:0] ref_rf  [32];
   logic [31:0] ref_pc;

   assign mem_rdata = mem[mem_addr[9:2]];
   always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

   mc_core dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .dbg_addr(dbg_addr),
      .dbg_data(dbg_data), .instr_start(instr_start)
   );

   int nchk = 0, nerr = 0;
   int p = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic emit(input logic [31:0] w);
      mem[p] = w; ref_mem[p] = w; p++;
   endtask

   function automatic int exp_len(input logic [31:0] w);
      case (w[31:26])
         6'h23: return 5;
         6'h2B: return 4;
         6'h00: return (w[10:6] == 0 && (w[5:0] == 6'h20 || w[5:0] == 6'h22)) ? 4 : 2;
         6'h04, 6'h02: return 3;
         default: return 2;
      endcase
   endfunction

   task automatic ref_step();
      logic [31:0] w, npc, se, ea;
      int rs, rt, rd;
      w = ref_mem[ref_pc[9:2]];
      npc = ref_pc + 4;
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      se = {{16{w[15]}}, w[15:0]};
      ea = ref_rf[rs] + se;
      ref_pc = npc;
      case (w[31:26])
         6'h00: if (w[10:6] == 0 && rd != 0) begin
            if (w[5:0] == 6'h20) ref_rf[rd] = ref_rf[rs] + ref_rf[rt];
            else if (w[5:0] == 6'h22) ref_rf[rd] = ref_rf[rs] - ref_rf[rt];
         end
         6'h23: if (rt != 0) ref_rf[rt] = ref_mem[ea[9:2]];
         6'h2B: ref_mem[ea[9:2]] = ref_rf[rt];
         6'h04: if (ref_rf[rs] == ref_rf[rt]) ref_pc = npc + {se[29:0], 2'b00};
         6'h02: ref_pc = {npc[31:28], w[25:0], 2'b00};
         default: ;
      endcase
   endtask

   function automatic string pc_tag(input logic [5:0] op);
      if (op == 6'h04) return "R8 branch target";
      if (op == 6'h02) return "R9 jump target";
      return "R2 sequential fetch";
   endfunction

   logic [31:0] halt_pc;

   initial begin : main
      logic [31:0] prev_w;
      bit have_prev;
      int cnt, total, halt_seen;
      void'($urandom(32'd2718));
      for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
      for (int i = 0; i < 32; i++) ref_rf[i] = '0;
      for (int i = 0; i < 15; i++) begin
         mem[128+i] = $urandom; ref_mem[128+i] = mem[128+i];
      end
      mem[128] = mem[128] | 32'h1; ref_mem[128] = mem[128];
      mem[143] = 32'h300; ref_mem[143] = 32'h300;

      for (int i = 1; i <= 8; i++) emit(enc_i(6'h23, 0, i, 16'(32'h200 + 4*(i-1))));
      emit(enc_i(6'h23, 0, 9, 16'h023C));
      emit(enc_r(1, 2, 0, 6'h20));
      for (int i = 0; i < 12; i++) begin
         int rd;
         rd = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(2, 8));
         emit(enc_r(int'($urandom_range(1, 8)), int'($urandom_range(1, 8)), rd,
                    $urandom_range(0, 1) ? 6'h22 : 6'h20));
      end
      emit(enc_r(1, 2, 7, 6'h24));
      emit(32'hFC00_0000);
      emit(enc_i(6'h2B, 9, 3, 16'hFFFC));
      emit(enc_i(6'h2B, 9, 4, 16'hFFF8));
      emit(enc_i(6'h2B, 0, 5, 16'h0280));
      emit(enc_i(6'h23, 9, 10, 16'hFFF8));
      emit(enc_i(6'h23, 9, 11, 16'hFFFC));
      emit(enc_i(6'h04, 1, 1, 16'h0003));
      emit(enc_r(1, 1, 12, 6'h20));
      emit(enc_r(1, 1, 12, 6'h20));
      emit(enc_r(1, 1, 12, 6'h20));
      emit(enc_r(2, 2, 13, 6'h20));
      emit(enc_r(1, 1, 14, 6'h22));
      emit(enc_i(6'h04, 14, 0, 16'h0001));
      emit(enc_r(1, 1, 15, 6'h20));
      emit(enc_i(6'h04, 1, 0, 16'h0002));
      emit(enc_r(2, 1, 16, 6'h22));
      emit({6'h02, 26'(p + 2)});
      emit(enc_r(1, 1, 17, 6'h20));
      emit(enc_r(2, 1, 18, 6'h20));
      halt_pc = 32'(p * 4);
      emit({6'h02, 26'(p)});

      ref_pc = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(mem_addr == 32'h0, "R1 first fetch address", mem_addr, 32'h0);
      chk(instr_start == 1'b1, "R1 fetch step after reset", 32'(instr_start), 32'h1);
      chk(mem_we == 1'b0, "R1 no write after reset", 32'(mem_we), 32'h0);

      have_prev = 0; cnt = 0; total = 0; halt_seen = 0; prev_w = '0;
      forever begin
         if (instr_start) begin
            if (have_prev)
               chk(cnt == exp_len(prev_w), $sformatf("R10 length of %h (R12 if unsupported)", prev_w),
                   32'(cnt), 32'(exp_len(prev_w)));
            chk(mem_addr == ref_pc, have_prev ? pc_tag(prev_w[31:26]) : "R2 sequential fetch",
                mem_addr, ref_pc);
            if (ref_pc == halt_pc) halt_seen++;
            if (halt_seen == 2) break;
            prev_w = ref_mem[ref_pc[9:2]];
            have_prev = 1;
            ref_step();
            cnt = 0;
         end
         chk(!(mem_we && cnt > 3), "R3 write only in store step", 32'(cnt), 32'd3);
         @(negedge clk);
         cnt++; total++;
         if (total > 20000) begin
            chk(1'b0, "watchdog", 32'(total), 32'd20000);
            break;
         end
      end

      for (int r = 0; r < 32; r++) begin
         dbg_addr = 5'(r);
         #1;
         chk(dbg_data == ref_rf[r],
             (r == 0) ? "R5 register zero" : $sformatf("R11 R4 R6 R12 register %0d", r),
             dbg_data, ref_rf[r]);
      end
      dbg_addr = 5'd10;
      #1;
      chk(dbg_data == ref_mem[190], "R6 reload of stored word", dbg_data, ref_mem[190]);
      for (int i = 128; i < 256; i++)
         chk(mem[i] == ref_mem[i], $sformatf("R7 memory word %0d", i), mem[i], ref_mem[i]);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule